// File: doc/BRIEF.md
# DMA Interrupt Status Register Bank

This block gathers the per-channel interrupt events of a multi-channel DMA engine and presents them to software as a small bank of 32-bit registers. Hardware raises single-cycle event pulses: underrun, overrun and generic channel events, bus-master errors, and terminal-count, pending-count and low-watermark events. Each pulse latches a raw bit. Software reads the raw bits and the masked status bits. It acknowledges a bit by writing a one to a clear address. It can force a bit by writing a one to a set address, which is useful for testing interrupt handlers.

Two interrupt words carry their own enable masks. The three event banks (terminal count, pending count and low watermark) have no mask and feed the interrupt directly. One combined interrupt line is driven high while any enabled status bit is set. A master-error log records which channel each bus master last reported as faulty.

Top module: `dmairq_bank`

## Requirements
- R1: After synchronous reset, every raw bit, enable bit, event-bank bit and master-log field reads zero, and `irq` is low.
- R2: In word group 0, an underrun pulse on channel n sets raw bit n and an overrun pulse on channel n sets raw bit 16+n. The group 0 raw word is read at 0x010.
- R3: In word group 1, a channel event on channel n sets raw bit n, and a bus-master error from master m sets raw bit 16+m. The group 1 raw word is read at 0x014. The master-error log at 0x04C holds master m's reported 4-bit channel number at bits 4m+3..4m.
- R4: Enable words are read/write at 0x008 (group 0) and 0x00C (group 1). The status words at 0x000 and 0x004 read as raw AND enable.
- R5: Writing to a clear address (0x018 and 0x01C for the groups; bank base + 4 for the event banks) clears every raw bit written as one and leaves the bits written as zero unchanged. Clear and set addresses read back zero.
- R6: Writing to a set address (0x020 and 0x024 for the groups; bank base + 8 for the event banks) sets every raw bit written as one. Bits that map to no channel or master are ignored.
- R7: The terminal-count, pending-count and low-watermark banks have their status words at 0x028, 0x034 and 0x040. Bit n of a bank is set by that bank's event pulse on channel n.
- R8: If a hardware event and a clear write hit the same bit in the same cycle, the bit ends up set.
- R9: `irq` is high exactly when any group status bit (raw AND enable) or any event-bank bit is set. It follows the register state with no further delay.
- R10: Writes to status, raw and master-log addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| ev_under | input | NCH | Underrun event pulses, one per channel |
| ev_over | input | NCH | Overrun event pulses |
| ev_chan | input | NCH | Generic channel event pulses |
| ev_term | input | NCH | Terminal-count event pulses |
| ev_pend | input | NCH | Pending-count event pulses |
| ev_lowwm | input | NCH | Low-watermark event pulses |
| merr_valid | input | NMST | Bus-master error pulse per master |
| merr_chan | input | 4*NMST | Faulting channel number per master, 4 bits each |
| irq | output | 1 | Combined interrupt |

## Verification
The assertions take it for granted that event pulses, master-error pulses and bus writes are sampled only at rising edges, and that reset is held for at least one edge before any check applies. The clear-effect property also assumes that no event pulse arrives in the same cycle as the write. The stimulus keeps to this by changing every input only on the falling edge, holding each pulse or write for exactly one cycle, and issuing simultaneous event and clear only in the one directed test meant to probe that case. It keeps NCH at 16 and NMST at 3, so bits 16..31 of the event banks and bits 19..31 of group 1 exercise the unmapped-bit masking.

// File: rtl/dmairq_pkg.sv
package dmairq_pkg;

    localparam int DW = 32;

    // Register byte offsets (software-visible map)
    localparam logic [7:0] OFF_STAT0 = 8'h00;
    localparam logic [7:0] OFF_STAT1 = 8'h04;
    localparam logic [7:0] OFF_EN0   = 8'h08;
    localparam logic [7:0] OFF_EN1   = 8'h0C;
    localparam logic [7:0] OFF_RAW0  = 8'h10;
    localparam logic [7:0] OFF_RAW1  = 8'h14;
    localparam logic [7:0] OFF_CLR0  = 8'h18;
    localparam logic [7:0] OFF_CLR1  = 8'h1C;
    localparam logic [7:0] OFF_SET0  = 8'h20;
    localparam logic [7:0] OFF_SET1  = 8'h24;
    localparam logic [7:0] OFF_TC    = 8'h28;
    localparam logic [7:0] OFF_PC    = 8'h34;
    localparam logic [7:0] OFF_LW    = 8'h40;
    localparam logic [7:0] OFF_MLOG  = 8'h4C;

    localparam int HALF     = 16;
    localparam int MLOG_FW  = 4;

    // One-hot write strobes produced by the decoder
    typedef struct packed {
        logic en0;
        logic en1;
        logic clr0;
        logic clr1;
        logic set0;
        logic set1;
        logic tc_clr;
        logic tc_set;
        logic pc_clr;
        logic pc_set;
        logic lw_clr;
        logic lw_set;
    } wstrobe_t;

    // Bank selector used by the generated event banks
    typedef enum logic [1:0] {
        BK_TC = 2'd0,
        BK_PC = 2'd1,
        BK_LW = 2'd2
    } bank_e;

    function automatic logic [DW-1:0] chan_mask(input int nch);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [DW-1:0] grp0_mask(input int nch);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) begin
            m[i]        = 1'b1;
            m[HALF + i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [DW-1:0] grp1_mask(input int nch, input int nm);
        logic [DW-1:0] m;
        m = '0;
        for (int i = 0; i < nch; i++) m[i] = 1'b1;
        for (int j = 0; j < nm; j++) m[HALF + j] = 1'b1;
        return m;
    endfunction

    function automatic logic [7:0] bank_base(input bank_e b);
        case (b)
            BK_TC:   return OFF_TC;
            BK_PC:   return OFF_PC;
            default: return OFF_LW;
        endcase
    endfunction

endpackage

// File: rtl/dmairq_bitreg.sv
module dmairq_bitreg #(
    parameter int             W    = 32,
    parameter logic [W-1:0]   MASK = '1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] hw_evt,
    input  logic         sw_clr,
    input  logic         sw_set,
    input  logic [W-1:0] sw_data,
    output logic [W-1:0] q
);
    logic [W-1:0] clr_bits;
    logic [W-1:0] set_bits;
    logic [W-1:0] nxt;

    always_comb begin
        clr_bits = sw_clr ? sw_data : '0;
        set_bits = sw_set ? sw_data : '0;
        // Events are ORed after the clear, so a same-cycle event survives
        nxt = ((q & ~clr_bits) | set_bits | hw_evt) & MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= nxt;
    end
endmodule

// File: rtl/dmairq_decode.sv
module dmairq_decode
    import dmairq_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    output wstrobe_t          ws
);
    function automatic logic hit(input logic [ADDR_W-1:0] a, input logic [7:0] off);
        return a == ADDR_W'(off);
    endfunction

    always_comb begin
        ws        = '0;
        ws.en0    = bus_wr && hit(bus_addr, OFF_EN0);
        ws.en1    = bus_wr && hit(bus_addr, OFF_EN1);
        ws.clr0   = bus_wr && hit(bus_addr, OFF_CLR0);
        ws.clr1   = bus_wr && hit(bus_addr, OFF_CLR1);
        ws.set0   = bus_wr && hit(bus_addr, OFF_SET0);
        ws.set1   = bus_wr && hit(bus_addr, OFF_SET1);
        ws.tc_clr = bus_wr && hit(bus_addr, bank_base(BK_TC) + 8'h4);
        ws.tc_set = bus_wr && hit(bus_addr, bank_base(BK_TC) + 8'h8);
        ws.pc_clr = bus_wr && hit(bus_addr, bank_base(BK_PC) + 8'h4);
        ws.pc_set = bus_wr && hit(bus_addr, bank_base(BK_PC) + 8'h8);
        ws.lw_clr = bus_wr && hit(bus_addr, bank_base(BK_LW) + 8'h4);
        ws.lw_set = bus_wr && hit(bus_addr, bank_base(BK_LW) + 8'h8);
    end
endmodule

// File: rtl/dmairq_merr_log.sv
module dmairq_merr_log
    import dmairq_pkg::*;
#(
    parameter int NMST = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [NMST-1:0]         merr_valid,
    input  logic [MLOG_FW*NMST-1:0] merr_chan,
    output logic [MLOG_FW*NMST-1:0] log_q
);
    for (genvar m = 0; m < NMST; m++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst)
                log_q[MLOG_FW*m +: MLOG_FW] <= '0;
            else if (merr_valid[m])
                log_q[MLOG_FW*m +: MLOG_FW] <= merr_chan[MLOG_FW*m +: MLOG_FW];
        end
    end
endmodule

// File: rtl/dmairq_bank.sv
module dmairq_bank
    import dmairq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int NMST   = 3,
    parameter int ADDR_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    bus_wr,
    input  logic [ADDR_W-1:0]       bus_addr,
    input  logic [31:0]             bus_wdata,
    output logic [31:0]             bus_rdata,
    input  logic [NCH-1:0]          ev_under,
    input  logic [NCH-1:0]          ev_over,
    input  logic [NCH-1:0]          ev_chan,
    input  logic [NCH-1:0]          ev_term,
    input  logic [NCH-1:0]          ev_pend,
    input  logic [NCH-1:0]          ev_lowwm,
    input  logic [NMST-1:0]         merr_valid,
    input  logic [4*NMST-1:0]       merr_chan,
    output logic                    irq
);
    localparam logic [DW-1:0]  M0   = grp0_mask(NCH);
    localparam logic [DW-1:0]  M1   = grp1_mask(NCH, NMST);
    localparam logic [NCH-1:0] MCH  = NCH'(chan_mask(NCH));
    localparam int             NBK  = 3;

    wstrobe_t        ws;
    logic [DW-1:0]   evt0, evt1;
    logic [DW-1:0]   raw0_q, raw1_q;
    logic [DW-1:0]   en0_q, en1_q;
    logic [NCH-1:0]  tc_q, pc_q, lw_q;
    logic [4*NMST-1:0] info_q;

    dmairq_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .ws      (ws)
    );

    // Map event pulses into the two group words
    always_comb begin
        evt0 = '0;
        evt1 = '0;
        for (int i = 0; i < NCH; i++) begin
            evt0[i]        = ev_under[i];
            evt0[HALF + i] = ev_over[i];
            evt1[i]        = ev_chan[i];
        end
        for (int j = 0; j < NMST; j++) evt1[HALF + j] = merr_valid[j];
    end

    dmairq_bitreg #(.W(DW), .MASK(M0)) u_raw0 (
        .clk(clk), .rst(rst), .hw_evt(evt0),
        .sw_clr(ws.clr0), .sw_set(ws.set0), .sw_data(bus_wdata), .q(raw0_q)
    );

    dmairq_bitreg #(.W(DW), .MASK(M1)) u_raw1 (
        .clk(clk), .rst(rst), .hw_evt(evt1),
        .sw_clr(ws.clr1), .sw_set(ws.set1), .sw_data(bus_wdata), .q(raw1_q)
    );

    // Three unmasked event banks built from one template
    logic [NCH-1:0] bk_evt [NBK];
    logic           bk_clr [NBK];
    logic           bk_set [NBK];
    logic [NCH-1:0] bk_q   [NBK];

    always_comb begin
        bk_evt[BK_TC] = ev_term;  bk_clr[BK_TC] = ws.tc_clr; bk_set[BK_TC] = ws.tc_set;
        bk_evt[BK_PC] = ev_pend;  bk_clr[BK_PC] = ws.pc_clr; bk_set[BK_PC] = ws.pc_set;
        bk_evt[BK_LW] = ev_lowwm; bk_clr[BK_LW] = ws.lw_clr; bk_set[BK_LW] = ws.lw_set;
    end

    for (genvar b = 0; b < NBK; b++) begin : g_bank
        dmairq_bitreg #(.W(NCH), .MASK(MCH)) u_bk (
            .clk(clk), .rst(rst), .hw_evt(bk_evt[b]),
            .sw_clr(bk_clr[b]), .sw_set(bk_set[b]),
            .sw_data(bus_wdata[NCH-1:0]), .q(bk_q[b])
        );
    end

    assign tc_q = bk_q[BK_TC];
    assign pc_q = bk_q[BK_PC];
    assign lw_q = bk_q[BK_LW];

    // Enable masks
    always_ff @(posedge clk) begin
        if (rst) begin
            en0_q <= '0;
            en1_q <= '0;
        end else begin
            if (ws.en0) en0_q <= bus_wdata & M0;
            if (ws.en1) en1_q <= bus_wdata & M1;
        end
    end

    dmairq_merr_log #(.NMST(NMST)) u_log (
        .clk(clk), .rst(rst), .merr_valid(merr_valid),
        .merr_chan(merr_chan), .log_q(info_q)
    );

    // Read mux
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(OFF_STAT0): bus_rdata = raw0_q & en0_q;
            ADDR_W'(OFF_STAT1): bus_rdata = raw1_q & en1_q;
            ADDR_W'(OFF_EN0):   bus_rdata = en0_q;
            ADDR_W'(OFF_EN1):   bus_rdata = en1_q;
            ADDR_W'(OFF_RAW0):  bus_rdata = raw0_q;
            ADDR_W'(OFF_RAW1):  bus_rdata = raw1_q;
            ADDR_W'(OFF_TC):    bus_rdata = DW'(tc_q);
            ADDR_W'(OFF_PC):    bus_rdata = DW'(pc_q);
            ADDR_W'(OFF_LW):    bus_rdata = DW'(lw_q);
            ADDR_W'(OFF_MLOG):  bus_rdata = DW'(info_q);
            default:            bus_rdata = '0;
        endcase
    end

    assign irq = (|(raw0_q & en0_q)) | (|(raw1_q & en1_q)) |
                 (|tc_q) | (|pc_q) | (|lw_q);

endmodule

// File: rtl/dmairq_bank_chk.sv
module dmairq_bank_chk
    import dmairq_pkg::*;
#(
    parameter int NCH    = 16,
    parameter int NMST   = 3,
    parameter int ADDR_W = 8
) (
    input logic               clk,
    input logic               rst,
    input logic               bus_wr,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_wdata,
    input logic [NCH-1:0]     ev_under,
    input logic [NCH-1:0]     ev_over,
    input logic [NCH-1:0]     ev_term,
    input logic [NMST-1:0]    merr_valid,
    input logic [4*NMST-1:0]  merr_chan,
    input logic [31:0]        raw0_q,
    input logic [NCH-1:0]     tc_q,
    input logic [4*NMST-1:0]  info_q,
    input logic               irq
);
    AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (raw0_q == '0 && tc_q == '0 && info_q == '0 && !irq)); // R1

    AST_UNDER_LATCH: assert property (@(posedge clk) disable iff (rst)
        (|ev_under) |=> ((raw0_q[NCH-1:0] & $past(ev_under)) == $past(ev_under))); // R2

    AST_MERR_LOG: assert property (@(posedge clk) disable iff (rst)
        merr_valid[0] |=> (info_q[3:0] == $past(merr_chan[3:0]))); // R3

    AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (|ev_term) |=> ((tc_q & $past(ev_term)) == $past(ev_term))); // R8

    AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_TC + 8'h4) && ev_term == '0)
        |=> ((tc_q & $past(bus_wdata[NCH-1:0])) == '0)); // R5

    AST_RAW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == ADDR_W'(OFF_RAW0) && ev_under == '0 && ev_over == '0)
        |=> $stable(raw0_q)); // R10

    AST_IRQ_FROM_BANK: assert property (@(posedge clk) disable iff (rst)
        (tc_q != '0) |-> irq); // R9
endmodule

bind dmairq_bank dmairq_bank_chk #(.NCH(NCH), .NMST(NMST), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .ev_under  (ev_under),
    .ev_over   (ev_over),
    .ev_term   (ev_term),
    .merr_valid(merr_valid),
    .merr_chan (merr_chan),
    .raw0_q    (raw0_q),
    .tc_q      (tc_q),
    .info_q    (info_q),
    .irq       (irq)
);

// File: tb/dmairq_bank_test.sv
module dmairq_bank_test;
    localparam int CLK_PERIOD = 10;
    localparam int NCH  = 16;
    localparam int NMST = 3;
    localparam int AW   = 8;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            bus_wr = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     bus_rdata;
    logic [NCH-1:0]  ev_under = '0, ev_over = '0, ev_chan = '0;
    logic [NCH-1:0]  ev_term = '0, ev_pend = '0, ev_lowwm = '0;
    logic [NMST-1:0] merr_valid = '0;
    logic [4*NMST-1:0] merr_chan = '0;
    logic            irq;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dmairq_bank #(.NCH(NCH), .NMST(NMST), .ADDR_W(AW)) uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .ev_under(ev_under), .ev_over(ev_over), .ev_chan(ev_chan),
        .ev_term(ev_term), .ev_pend(ev_pend), .ev_lowwm(ev_lowwm),
        .merr_valid(merr_valid), .merr_chan(merr_chan), .irq(irq)
    );

    // {is_write, addr, data, expected read}
    localparam int NV = 24;
    localparam logic [72:0] VEC [NV] = '{
        {1'b1, 8'h20, 32'h0003_0005, 32'h0},          // R6 set group0
        {1'b0, 8'h10, 32'h0,         32'h0003_0005},  // R6
        {1'b0, 8'h00, 32'h0,         32'h0000_0000},  // R4 no enable yet
        {1'b1, 8'h08, 32'h0001_0004, 32'h0},
        {1'b0, 8'h00, 32'h0,         32'h0001_0004},  // R4 masked status
        {1'b1, 8'h18, 32'h0000_0001, 32'h0},
        {1'b0, 8'h10, 32'h0,         32'h0003_0004},  // R5 only bit0 cleared
        {1'b1, 8'h24, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h14, 32'h0,         32'h0007_FFFF},  // R6 unmapped bits dropped
        {1'b1, 8'h1C, 32'h0005_00F0, 32'h0},
        {1'b0, 8'h14, 32'h0,         32'h0002_FF0F},  // R5 group1 clear
        {1'b1, 8'h30, 32'h0000_0081, 32'h0},
        {1'b0, 8'h28, 32'h0,         32'h0000_0081},  // R7 tc set
        {1'b1, 8'h2C, 32'h0000_0001, 32'h0},
        {1'b0, 8'h28, 32'h0,         32'h0000_0080},  // R5 tc clear
        {1'b1, 8'h3C, 32'h0001_0000, 32'h0},
        {1'b0, 8'h34, 32'h0,         32'h0000_0000},  // R6 bit above channels ignored
        {1'b1, 8'h48, 32'h0000_A000, 32'h0},
        {1'b0, 8'h40, 32'h0,         32'h0000_A000},  // R7 lw set
        {1'b1, 8'h00, 32'hFFFF_FFFF, 32'h0},
        {1'b1, 8'h10, 32'hFFFF_FFFF, 32'h0},
        {1'b0, 8'h10, 32'h0,         32'h0003_0004},  // R10 raw/status writes ignored
        {1'b0, 8'h08, 32'h0,         32'h0001_0004},  // R4 enable readback
        {1'b0, 8'h18, 32'h0,         32'h0000_0000}   // R5 clear addr reads zero
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [7:0] a, input logic [31:0] exp);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        rd_check("R1 raw0", 8'h10, 32'h0);
        rd_check("R1 raw1", 8'h14, 32'h0);
        rd_check("R1 tc",   8'h28, 32'h0);
        rd_check("R1 mlog", 8'h4C, 32'h0);
        check("R1 irq", {31'h0, irq}, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][72]) wr(VEC[i][71:64], VEC[i][63:32]);
            else rd_check($sformatf("vec%0d", i), VEC[i][71:64], VEC[i][31:0]);
        end

        do_reset();
        // R2 under/over event positions
        @(negedge clk); ev_under[3] = 1'b1; ev_over[5] = 1'b1;
        @(negedge clk); ev_under = '0; ev_over = '0;
        rd_check("R2 raw0", 8'h10, 32'h0020_0008);

        // R3 master error and channel event
        @(negedge clk); merr_valid = 3'b010; merr_chan = 12'h0A0; ev_chan[7] = 1'b1;
        @(negedge clk); merr_valid = '0; merr_chan = '0; ev_chan = '0;
        rd_check("R3 raw1", 8'h14, 32'h0002_0080);
        rd_check("R3 mlog", 8'h4C, 32'h0000_00A0);

        check("R9 irq quiet", {31'h0, irq}, 32'h0);

        // R7 event banks
        @(negedge clk); ev_term[9] = 1'b1; ev_pend[0] = 1'b1; ev_lowwm[15] = 1'b1;
        @(negedge clk); ev_term = '0; ev_pend = '0; ev_lowwm = '0;
        rd_check("R7 tc", 8'h28, 32'h0000_0200);
        rd_check("R7 pc", 8'h34, 32'h0000_0001);
        rd_check("R7 lw", 8'h40, 32'h0000_8000);
        check("R9 irq bank", {31'h0, irq}, 32'h1);

        wr(8'h2C, 32'hFFFF); wr(8'h38, 32'hFFFF); wr(8'h44, 32'hFFFF);
        #1;
        check("R9 irq cleared", {31'h0, irq}, 32'h0);
        wr(8'h0C, 32'h0002_0000);
        #1;
        check("R9 irq enabled", {31'h0, irq}, 32'h1);
        rd_check("R4 stat1", 8'h04, 32'h0002_0000);

        // R8 event vs clear in one cycle
        wr(8'h30, 32'h4);
        @(negedge clk);
        ev_term[2] = 1'b1; bus_addr = 8'h2C; bus_wdata = 32'h4; bus_wr = 1'b1;
        @(negedge clk);
        ev_term = '0; bus_wr = 1'b0;
        rd_check("R8 event wins", 8'h28, 32'h0000_0004);
        wr(8'h2C, 32'h4);
        rd_check("R5 tc cleared", 8'h28, 32'h0);

        // R10 master log is read-only
        wr(8'h4C, 32'hFFFF_FFFF);
        rd_check("R10 mlog", 8'h4C, 32'h0000_00A0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule